// File: doc/BRIEF.md
# Dual-Channel DAC Serial Command Decoder

This block is the digital front end of a two-channel, 10-bit converter. A host sends 16-bit words over a three-wire serial link made of an active-low select, a serial clock and a data line. While select is low, each rising serial clock shifts one bit in, MSB first. When select rises, the word is decoded. Each channel has two registers: a staging (input) register and an output (DAC) register. A command can write either kind, copy staging into output, or request a shutdown. The two output codes go to the converters. One-cycle strobes, with their load-select bits, go to a separate power-state controller.

All serial pins are sampled by a system clock that runs at least four times faster than the serial clock. Three pins are separate from the serial link. The load pin (active low) copies staging into output with no serial traffic. The clear pin (active low) forces all four registers to a reset code. The reset-code pin picks that code: zero or midscale. A serial data output shifts out the MSB of the shift register, for readback and for chaining several blocks. A sub-command picks which serial clock edge updates that output.

Top module: `dac_cmd_decoder`

## Requirements
- R1: While power-on reset (`rst_n`) or clear (`clr_n`) is low, all four registers hold the reset code, with no clock edge needed. The reset code is 0x000 when `rst_mid` is 0 and 0x200 when it is 1. Clear also returns the data-out mode to mode 0. After power-on reset, `sdo` is 0.
- R2: While `cs_n` is low, each rising `sclk` shifts `sdi` into a 16-bit register. The frame is decoded on the rising edge of `cs_n`. Bits [15:13] are the command, [12:3] the 10-bit data D9..D0, and [2:0] the sub-bits, which are ignored.
- R3: A frame whose bit count is not exactly 16 when `cs_n` rises changes no register and emits no strobe. When parameter `ERR_FLAG_EN` is 1, such a frame gives a one-cycle pulse on `frame_err`.
- R4: Command 001 writes the data to staging A only. Command 101 writes the data to staging B only. Neither changes an output register or emits a wake.
- R5: Command 010 writes the data to staging A and to output A, and copies staging B to output B. Command 110 writes the data to staging B and output B, and copies staging A to output A. Both commands wake both channels.
- R6: Command 011 writes the data to all four registers. Command 100 copies both staging registers into their output registers and ignores the data. Both commands wake both channels.
- R7: Command 000 with D9..D7 = 001 copies staging A to output A and wakes A only. With D9..D7 = 101 it copies staging B to output B and wakes B only.
- R8: Command 111 pulses `sd_a` and `sd_b` in the same cycle, with `sd_load_a`=D9 and `sd_load_b`=D8. Command 000 with D9..D7 = 110 pulses `sd_a` with `sd_load_a`=D6. With D9..D7 = 111 it pulses `sd_b` with `sd_load_b`=D6.
- R9: Command 000 with D9..D7 = 011 pulses `pd_all` with `sd_load_a`=D6 and `sd_load_b`=D5. Command 000 with D9..D6 = 0000 changes nothing and emits no strobe.
- R10: Command 000 with D9..D6 = 1000 selects mode 0, which is the default. In mode 0, `sdo` takes the shift register MSB after each falling `sclk`. D9..D6 = 1001 selects mode 1. In mode 1, `sdo` takes the new MSB after each rising `sclk`, so a stream reappears on `sdo` 15 clocks after it entered.
- R11: While `ldac_n` is low, both output registers follow their staging registers. If a frame writes a staging register while `ldac_n` is low, the newly written value reaches the output. The load pin emits no wake.
- R12: `wake_a`, `wake_b`, `sd_a`, `sd_b`, `pd_all` and `frame_err` are pulses one system clock long. Every serial command that writes an output register wakes that channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous |
| cs_n | input | 1 | Serial select, active low |
| sclk | input | 1 | Serial clock |
| sdi | input | 1 | Serial data in |
| ldac_n | input | 1 | Load outputs from staging, active low |
| clr_n | input | 1 | Clear to reset code, active low, asynchronous |
| rst_mid | input | 1 | Reset code select: 0 = zero, 1 = midscale |
| sdo | output | 1 | Serial data out |
| code_a | output | 10 | Output register A |
| code_b | output | 10 | Output register B |
| wake_a | output | 1 | Channel A wake strobe |
| wake_b | output | 1 | Channel B wake strobe |
| sd_a | output | 1 | Channel A shutdown strobe |
| sd_b | output | 1 | Channel B shutdown strobe |
| pd_all | output | 1 | Full power-down strobe |
| sd_load_a | output | 1 | Load select for A, valid with its strobe |
| sd_load_b | output | 1 | Load select for B, valid with its strobe |
| frame_err | output | 1 | Bad-length frame pulse |

## Verification
The assertions assume three things about the inputs. Select, serial clock and load are slow enough that consecutive select edges are several system clocks apart. Serial clock does not toggle in the same system cycle as a select edge. Clear, once asserted, is held across at least one system clock edge. The stimulus meets all three. It holds every serial clock phase and every select setup for six system clocks, and it holds clear low for two system clocks.

// File: rtl/dac_cmd_pkg.sv
package dac_cmd_pkg;
    localparam int FRAME_BITS = 16;
    localparam int DATA_W     = 10;
    localparam int CNT_W      = $clog2(FRAME_BITS) + 1;
    localparam int CMD_HI     = FRAME_BITS - 1;
    localparam int DATA_HI    = FRAME_BITS - 4;
    localparam int DATA_LO    = DATA_HI - DATA_W + 1;

    typedef enum logic [2:0] {
        CMD_EXT     = 3'b000,
        CMD_STG_A   = 3'b001,
        CMD_STG_A_U = 3'b010,
        CMD_ALL     = 3'b011,
        CMD_XFER    = 3'b100,
        CMD_STG_B   = 3'b101,
        CMD_STG_B_U = 3'b110,
        CMD_SD_BOTH = 3'b111
    } cmd_e;

    typedef struct packed {
        logic                   sclk_p;
        logic                   cs_p;
        logic [FRAME_BITS-1:0]  sreg;
        logic [CNT_W-1:0]       cnt;
        logic                   ok;
        logic                   bad;
        logic [FRAME_BITS-1:0]  word;
        logic                   sdo;
    } rx_state_t;

    typedef struct packed {
        logic [DATA_W-1:0] stg_a;
        logic [DATA_W-1:0] stg_b;
        logic [DATA_W-1:0] out_a;
        logic [DATA_W-1:0] out_b;
        logic              mode1;
        logic              wake_a;
        logic              wake_b;
        logic              sd_a;
        logic              sd_b;
        logic              pd;
        logic              ld_a;
        logic              ld_b;
    } exec_state_t;
endpackage

// File: rtl/dac_pin_sync.sv
module dac_pin_sync #(
    parameter int               WIDTH   = 4,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0] chain_q [STAGES];
    logic [WIDTH-1:0] chain_d [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_comb chain_d[s] = din;
        end else begin : g_next
            always_comb chain_d[s] = chain_q[s-1];
        end
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[s] <= RST_VAL;
            else        chain_q[s] <= chain_d[s];
        end
    end

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/dac_serial_rx.sv
module dac_serial_rx
    import dac_cmd_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cs_n_s,
    input  logic                  sclk_s,
    input  logic                  sdi_s,
    input  logic                  mode1,
    output logic                  frame_ok,
    output logic                  frame_bad,
    output logic [FRAME_BITS-1:0] frame_word,
    output logic                  sdo
);
    localparam logic [CNT_W-1:0] CNT_MAX  = '1;
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_BITS);

    rx_state_t q, d;

    always_comb begin
        logic rise, fall, cs_rise, cs_fall;
        logic [CNT_W-1:0]      base;
        logic [FRAME_BITS-1:0] shifted;
        d       = q;
        d.ok    = 1'b0;
        d.bad   = 1'b0;
        d.sclk_p = sclk_s;
        d.cs_p   = cs_n_s;
        rise    = sclk_s & ~q.sclk_p;
        fall    = ~sclk_s & q.sclk_p;
        cs_rise = cs_n_s & ~q.cs_p;
        cs_fall = ~cs_n_s & q.cs_p;
        base    = cs_fall ? '0 : q.cnt;
        shifted = {q.sreg[FRAME_BITS-2:0], sdi_s};
        d.cnt   = base;
        if (!cs_n_s && rise) begin
            d.sreg = shifted;
            d.cnt  = (base == CNT_MAX) ? CNT_MAX : base + 1'b1;
            if (mode1) d.sdo = shifted[FRAME_BITS-1];
        end
        if (!cs_n_s && fall && !mode1) d.sdo = q.sreg[FRAME_BITS-1];
        if (cs_rise) begin
            if (q.cnt == CNT_FULL) begin
                d.ok   = 1'b1;
                d.word = q.sreg;
            end else begin
                d.bad = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q        <= '0;
            q.cs_p   <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign frame_ok   = q.ok;
    assign frame_bad  = q.bad;
    assign frame_word = q.word;
    assign sdo        = q.sdo;

    a_r3_len_gate: assert property (@(posedge clk) disable iff (!rst_n)
        q.ok |-> ($past(q.cnt) == CNT_FULL));
    a_r3_ok_or_bad: assert property (@(posedge clk) disable iff (!rst_n)
        !(q.ok && q.bad));
    a_r2_count_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n_s && q.cs_p) |=> (q.cnt <= CNT_W'(1)));
endmodule

// File: rtl/dac_cmd_exec.sv
module dac_cmd_exec
    import dac_cmd_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [DATA_W-1:0]     rst_code,
    input  logic                  frame_ok,
    input  logic [FRAME_BITS-1:0] frame_word,
    input  logic                  ldac,
    output logic [DATA_W-1:0]     code_a,
    output logic [DATA_W-1:0]     code_b,
    output logic                  mode1,
    output logic                  wake_a,
    output logic                  wake_b,
    output logic                  sd_a,
    output logic                  sd_b,
    output logic                  pd_all,
    output logic                  ld_a,
    output logic                  ld_b
);
    exec_state_t q, d;
    exec_state_t rst_state;

    always_comb begin
        rst_state       = '0;
        rst_state.stg_a = rst_code;
        rst_state.stg_b = rst_code;
        rst_state.out_a = rst_code;
        rst_state.out_b = rst_code;
    end

    always_comb begin
        cmd_e              cmd;
        logic [DATA_W-1:0] dat;
        logic [3:0]        sub;
        cmd = cmd_e'(frame_word[CMD_HI -: 3]);
        dat = frame_word[DATA_HI:DATA_LO];
        sub = dat[DATA_W-1 -: 4];
        d        = q;
        d.wake_a = 1'b0;
        d.wake_b = 1'b0;
        d.sd_a   = 1'b0;
        d.sd_b   = 1'b0;
        d.pd     = 1'b0;
        if (frame_ok) begin
            unique case (cmd)
                CMD_STG_A: d.stg_a = dat;
                CMD_STG_B: d.stg_b = dat;
                CMD_STG_A_U: begin
                    d.stg_a = dat;  d.out_a = dat;  d.out_b = q.stg_b;
                    d.wake_a = 1'b1; d.wake_b = 1'b1;
                end
                CMD_STG_B_U: begin
                    d.stg_b = dat;  d.out_b = dat;  d.out_a = q.stg_a;
                    d.wake_a = 1'b1; d.wake_b = 1'b1;
                end
                CMD_ALL: begin
                    d.stg_a = dat; d.stg_b = dat; d.out_a = dat; d.out_b = dat;
                    d.wake_a = 1'b1; d.wake_b = 1'b1;
                end
                CMD_XFER: begin
                    d.out_a = q.stg_a; d.out_b = q.stg_b;
                    d.wake_a = 1'b1; d.wake_b = 1'b1;
                end
                CMD_SD_BOTH: begin
                    d.sd_a = 1'b1; d.sd_b = 1'b1;
                    d.ld_a = dat[DATA_W-1]; d.ld_b = dat[DATA_W-2];
                end
                CMD_EXT: begin
                    casez (sub)
                        4'b001?: begin d.out_a = q.stg_a; d.wake_a = 1'b1; end
                        4'b101?: begin d.out_b = q.stg_b; d.wake_b = 1'b1; end
                        4'b011?: begin d.pd = 1'b1; d.ld_a = sub[0]; d.ld_b = dat[DATA_W-5]; end
                        4'b110?: begin d.sd_a = 1'b1; d.ld_a = sub[0]; end
                        4'b111?: begin d.sd_b = 1'b1; d.ld_b = sub[0]; end
                        4'b1000: d.mode1 = 1'b0;
                        4'b1001: d.mode1 = 1'b1;
                        default: ;
                    endcase
                end
                default: ;
            endcase
        end
        if (ldac) begin
            d.out_a = d.stg_a;
            d.out_b = d.stg_b;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= rst_state;
        else        q <= d;
    end

    assign code_a = q.out_a;
    assign code_b = q.out_b;
    assign mode1  = q.mode1;
    assign wake_a = q.wake_a;
    assign wake_b = q.wake_b;
    assign sd_a   = q.sd_a;
    assign sd_b   = q.sd_b;
    assign pd_all = q.pd;
    assign ld_a   = q.ld_a;
    assign ld_b   = q.ld_b;

    a_r4_staging_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_ok |=> ($stable(q.stg_a) && $stable(q.stg_b)));
    a_r11_output_source: assert property (@(posedge clk) disable iff (!rst_n)
        (!frame_ok && !ldac) |=> ($stable(q.out_a) && $stable(q.out_b)));
    a_r12_strobe_classes: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({q.pd, q.sd_a | q.sd_b, q.wake_a | q.wake_b}));
    a_r12_pulse_width: assert property (@(posedge clk) disable iff (!rst_n)
        (q.wake_a || q.sd_a || q.pd) |=> !(q.wake_a || q.sd_a || q.pd));
    a_r10_mode_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_ok |=> $stable(q.mode1));
endmodule

// File: rtl/dac_cmd_decoder.sv
module dac_cmd_decoder
    import dac_cmd_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter bit ERR_FLAG_EN = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              sclk,
    input  logic              sdi,
    input  logic              ldac_n,
    input  logic              clr_n,
    input  logic              rst_mid,
    output logic              sdo,
    output logic [DATA_W-1:0] code_a,
    output logic [DATA_W-1:0] code_b,
    output logic              wake_a,
    output logic              wake_b,
    output logic              sd_a,
    output logic              sd_b,
    output logic              pd_all,
    output logic              sd_load_a,
    output logic              sd_load_b,
    output logic              frame_err
);
    localparam int PIN_N = 4;

    logic [PIN_N-1:0]      pins_s;
    logic                  regs_rst_n;
    logic [DATA_W-1:0]     rst_code;
    logic                  frame_ok, frame_bad, mode1;
    logic [FRAME_BITS-1:0] frame_word;

    assign regs_rst_n = rst_n & clr_n;
    assign rst_code   = {rst_mid, {(DATA_W-1){1'b0}}};

    dac_pin_sync #(
        .WIDTH  (PIN_N),
        .STAGES (SYNC_STAGES),
        .RST_VAL(4'b1001)
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({ldac_n, sdi, sclk, cs_n}),
        .dout (pins_s)
    );

    dac_serial_rx u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n_s    (pins_s[0]),
        .sclk_s    (pins_s[1]),
        .sdi_s     (pins_s[2]),
        .mode1     (mode1),
        .frame_ok  (frame_ok),
        .frame_bad (frame_bad),
        .frame_word(frame_word),
        .sdo       (sdo)
    );

    dac_cmd_exec u_exec (
        .clk       (clk),
        .rst_n     (regs_rst_n),
        .rst_code  (rst_code),
        .frame_ok  (frame_ok),
        .frame_word(frame_word),
        .ldac      (~pins_s[3]),
        .code_a    (code_a),
        .code_b    (code_b),
        .mode1     (mode1),
        .wake_a    (wake_a),
        .wake_b    (wake_b),
        .sd_a      (sd_a),
        .sd_b      (sd_b),
        .pd_all    (pd_all),
        .ld_a      (sd_load_a),
        .ld_b      (sd_load_b)
    );

    if (ERR_FLAG_EN) begin : g_err
        assign frame_err = frame_bad;
    end else begin : g_no_err
        assign frame_err = 1'b0;
    end

    a_r1_clear_value: assert property (@(posedge clk)
        (!rst_n || !clr_n) |-> (code_a == rst_code && code_b == rst_code));
    a_r3_bad_quiet: assert property (@(posedge clk) disable iff (!regs_rst_n)
        frame_err |-> !(wake_a || wake_b || sd_a || sd_b || pd_all));
endmodule

// File: tb/sim_dac_cmd_decoder.sv
module sim_dac_cmd_decoder;
    logic clk = 1'b0;
    logic rst_n = 1'b0, cs_n = 1'b1, sclk = 1'b0, sdi = 1'b0;
    logic ldac_n = 1'b1, clr_n = 1'b1, rst_mid = 1'b0;
    logic sdo, wake_a, wake_b, sd_a, sd_b, pd_all, sd_load_a, sd_load_b, frame_err;
    logic [9:0] code_a, code_b;

    int checks = 0, errors = 0;
    int m_sa, m_sb, m_oa, m_ob;
    int n_wa, n_wb, n_sa, n_sb, n_pd, n_er;
    logic cap_la, cap_lb;
    bit busy = 1'b1;
    string cur_req = "R1";

    always #10 clk = ~clk;

    dac_cmd_decoder u0 (.*);

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic clks(int n);
        repeat (n) @(negedge clk);
    endtask

    always @(negedge clk) begin
        if (wake_a) n_wa++;
        if (wake_b) n_wb++;
        if (sd_a) begin n_sa++; cap_la = sd_load_a; end
        if (sd_b) begin n_sb++; cap_lb = sd_load_b; end
        if (pd_all) begin n_pd++; cap_la = sd_load_a; cap_lb = sd_load_b; end
        if (frame_err) n_er++;
        if (!busy && rst_n) begin
            chk({cur_req, " code_a"}, int'(code_a), m_oa);
            chk({cur_req, " code_b"}, int'(code_b), m_ob);
        end
    end

    // Shifts n bits (MSB of the n-bit field first); sdo checked when ck=1 (mode 1) or ck=2 (mode 0)
    task automatic shift(logic [31:0] bits, int n, int ck, logic [15:0] ref_w);
        cs_n = 1'b0;
        clks(6);
        for (int i = 0; i < n; i++) begin
            logic prev;
            sdi = bits[n-1-i];
            clks(6);
            prev = sdo;
            sclk = 1'b1;
            clks(5);
            if (ck == 1 && i >= 15 && i < 31)
                chk("R10 mode1 sdo after rise", int'(sdo), int'(ref_w[15-(i-15)]));
            if (ck == 2 && i >= 16 && i < 32)
                chk("R10 mode0 sdo holds on rise", int'(sdo), int'(prev));
            clks(1);
            sclk = 1'b0;
            clks(5);
            if (ck == 2 && i >= 15 && i < 31)
                chk("R10 mode0 sdo after fall", int'(sdo), int'(ref_w[15-(i-15)]));
        end
        clks(6);
    endtask

    task automatic frame(string req, logic [31:0] bits, int n, int ck, logic [15:0] ref_w);
        int ewa, ewb, esa, esb, epd, eer;
        logic ela, elb;
        logic [2:0] c;
        logic [9:0] dt;
        cur_req = req;
        shift(bits, n, ck, ref_w);
        n_wa = 0; n_wb = 0; n_sa = 0; n_sb = 0; n_pd = 0; n_er = 0;
        busy = 1'b1;
        cs_n = 1'b1;
        clks(8);
        ewa = 0; ewb = 0; esa = 0; esb = 0; epd = 0; eer = 0; ela = 0; elb = 0;
        c  = bits[15:13];
        dt = bits[12:3];
        if (n != 16) eer = 1;
        else begin
            case (c)
                3'b001: m_sa = dt;
                3'b101: m_sb = dt;
                3'b010: begin m_sa = dt; m_oa = dt; m_ob = m_sb; ewa = 1; ewb = 1; end
                3'b110: begin m_sb = dt; m_ob = dt; m_oa = m_sa; ewa = 1; ewb = 1; end
                3'b011: begin m_sa = dt; m_sb = dt; m_oa = dt; m_ob = dt; ewa = 1; ewb = 1; end
                3'b100: begin m_oa = m_sa; m_ob = m_sb; ewa = 1; ewb = 1; end
                3'b111: begin esa = 1; esb = 1; ela = dt[9]; elb = dt[8]; end
                default: begin
                    if (dt[9:7] == 3'b001) begin m_oa = m_sa; ewa = 1; end
                    if (dt[9:7] == 3'b101) begin m_ob = m_sb; ewb = 1; end
                    if (dt[9:7] == 3'b011) begin epd = 1; ela = dt[6]; elb = dt[5]; end
                    if (dt[9:7] == 3'b110) begin esa = 1; ela = dt[6]; end
                    if (dt[9:7] == 3'b111) begin esb = 1; elb = dt[6]; end
                end
            endcase
        end
        if (!ldac_n) begin m_oa = m_sa; m_ob = m_sb; end
        chk({req, " wake_a count"}, n_wa, ewa);
        chk({req, " wake_b count"}, n_wb, ewb);
        chk({req, " sd_a count"}, n_sa, esa);
        chk({req, " sd_b count"}, n_sb, esb);
        chk({req, " pd_all count"}, n_pd, epd);
        chk({req, " frame_err count"}, n_er, eer);
        if (esa || epd) chk({req, " load A"}, int'(cap_la), int'(ela));
        if (esb || epd) chk({req, " load B"}, int'(cap_lb), int'(elb));
        busy = 1'b0;
        clks(2);
    endtask

    function automatic logic [31:0] w(logic [2:0] c, logic [9:0] d);
        return {16'h0, c, d, 3'b000};
    endfunction

    initial begin
        #(200000 * 20);
        checks++; errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        m_sa = 0; m_sb = 0; m_oa = 0; m_ob = 0;
        clks(4);
        cur_req = "R1";
        chk("R1 code_a in reset", int'(code_a), 0);
        rst_n = 1'b1;
        clks(3);
        chk("R1 sdo after reset", int'(sdo), 0);
        busy = 1'b0;
        clks(2);

        frame("R4", w(3'b001, 10'h155), 16, 0, 16'h0);
        frame("R4", w(3'b101, 10'h2AA), 16, 0, 16'h0);
        frame("R6", w(3'b100, 10'h3C7), 16, 0, 16'h0);
        frame("R5", w(3'b010, 10'h3FF), 16, 0, 16'h0);
        frame("R5", w(3'b110, 10'h001), 16, 0, 16'h0);
        frame("R6", w(3'b011, 10'h123), 16, 0, 16'h0);
        frame("R4", w(3'b001, 10'h050), 16, 0, 16'h0);
        frame("R7", w(3'b000, 10'b0010_000000), 16, 0, 16'h0);
        frame("R4", w(3'b101, 10'h060), 16, 0, 16'h0);
        frame("R7", w(3'b000, 10'b1011_111111), 16, 0, 16'h0);
        frame("R8", w(3'b111, 10'b10_00000000), 16, 0, 16'h0);
        frame("R8", w(3'b000, 10'b1101_000000), 16, 0, 16'h0);
        frame("R8", w(3'b000, 10'b1110_000000), 16, 0, 16'h0);
        frame("R9", w(3'b000, 10'b0110_100000), 16, 0, 16'h0);
        frame("R9", w(3'b000, 10'b0000_111111), 16, 0, 16'h0);
        frame("R3", {17'h0, 15'h2AAA}, 15, 0, 16'h0);
        frame("R3", {15'h0, 17'h0FFF8}, 17, 0, 16'h0);
        frame("R2", w(3'b011, 10'h2C5), 16, 0, 16'h0);

        frame("R10", w(3'b000, 10'b1001_000000), 16, 0, 16'h0);
        frame("R10", {16'hB3C5, 16'h1234}, 32, 1, 16'hB3C5);
        frame("R10", w(3'b000, 10'b1000_000000), 16, 0, 16'h0);
        frame("R10", {16'h5A96, 16'h0F0F}, 32, 2, 16'h5A96);

        frame("R11", w(3'b001, 10'h0AA), 16, 0, 16'h0);
        busy = 1'b1; cur_req = "R11";
        n_wa = 0; n_wb = 0;
        ldac_n = 1'b0;
        clks(6);
        m_oa = m_sa; m_ob = m_sb;
        chk("R11 load pin no wake", n_wa + n_wb, 0);
        busy = 1'b0;
        frame("R11", w(3'b101, 10'h3C3), 16, 0, 16'h0);
        ldac_n = 1'b1;
        clks(6);

        busy = 1'b1; cur_req = "R1";
        rst_mid = 1'b1;
        clr_n = 1'b0;
        #3;
        chk("R1 clear midscale code_a", int'(code_a), 'h200);
        chk("R1 clear midscale code_b", int'(code_b), 'h200);
        clks(2);
        clr_n = 1'b1;
        m_sa = 'h200; m_sb = 'h200; m_oa = 'h200; m_ob = 'h200;
        clks(2);
        busy = 1'b0;
        frame("R1", w(3'b100, 10'h000), 16, 0, 16'h0);
        busy = 1'b1;
        rst_mid = 1'b0;
        clr_n = 1'b0;
        #3;
        chk("R1 clear zero code_a", int'(code_a), 0);
        clks(2);
        clr_n = 1'b1;
        m_sa = 0; m_sb = 0; m_oa = 0; m_ob = 0;
        clks(2);
        busy = 1'b0;
        frame("R12", w(3'b010, 10'h3A5), 16, 0, 16'h0);
        clks(4);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule